// File: doc/BRIEF.md
# Cross-Referenced Dual Clock Monitor

This block watches two clocks at once: an external clock and a low-frequency internal base clock that sits near 307.2 kHz. Each clock is divided down into a slow reference clock. That reference then decides whether the *other* clock is still alive. The reference taken from the external clock checks the base clock. The reference taken from the base clock checks the external clock.

Both paths always divide by four. One of the two paths also gets a longer divider, which keeps each reference at no more than half the rate of the clock it checks. The slow-external bit chooses which path gets the longer divider. When the long divider sits on the external path, the crystal-enable bit doubles it.

Each detector runs in the clock domain that produces its reference. A capture flop, clocked by the monitored clock, records whether that clock ticked. The detector samples this flop once per reference period and then wipes it. Two empty reference periods in a row raise a sticky failure flag. The flag stays high until the monitor is disabled, a clear is applied, or reset is applied.

Top module: `xclk_monitor`

## Requirements
- R1: With `ext_slow`=0 and `xtal_en`=0, `eref` has a period of 128 external-clock periods. With `ext_slow`=0 and `xtal_en`=1, the period is 256. With `ext_slow`=1, the period is 4.
- R2: With `ext_slow`=0, `iref` has a period of 4 base-clock periods. With `ext_slow`=1, the period is 128.
- R3: When `ext_slow`=1, `xtal_en` has no effect on the period of either reference.
- R4: With `en`=1 and both clocks running so that each reference is at most half the rate of the clock it checks, neither `ext_fail` nor `int_fail` is ever set.
- R5: If the external clock stops while `en`=1, `ext_fail` goes to 1 within four `iref` periods. It rises only in the base-clock cycle after a rising edge of `iref`. `int_fail` stays 0.
- R6: If the base clock stops while `en`=1, `int_fail` goes to 1 within four `eref` periods. It rises only in the external-clock cycle after a rising edge of `eref`. `ext_fail` stays 0.
- R7: A failure flag that is set stays at 1 after its clock resumes. It falls only after `en`=0, `clr`=1 or `rst`=1 has passed through the two-stage synchroniser of its domain.
- R8: Holding `clr` at 1 for at least three cycles of each clock returns a set failure flag to 0, provided the monitored clock is running again.
- R9: While `en`=0, both failure flags are held at 0. This holds within three cycles of the flag's own domain, and it holds even if a clock stops.
- R10: While `rst`=1, with both clocks running, `eref`, `iref`, `ext_fail` and `int_fail` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_clk | input | 1 | External clock under watch; also clocks the `eref` domain |
| ibase_clk | input | 1 | Internal base clock under watch; also clocks the `iref` domain |
| rst | input | 1 | Active-high reset, sampled synchronously in both domains |
| en | input | 1 | Monitor enable, synchronised into both domains |
| clr | input | 1 | Clears the failure flags, synchronised into both domains |
| ext_slow | input | 1 | 0 puts the long divider on the external path; 1 puts it on the base path |
| xtal_en | input | 1 | Doubles the long divider when that divider is on the external path |
| eref | output | 1 | Reference divided from the external clock; checks the base clock |
| iref | output | 1 | Reference divided from the base clock; checks the external clock |
| ext_fail | output | 1 | Sticky flag: the external clock showed no activity |
| int_fail | output | 1 | Sticky flag: the base clock showed no activity |

## Verification
The assertions check three things on every cycle of each domain:
- a failure flag rises only in the cycle after its reference rises;
- a set flag drops only when a synchronised disable, clear or reset explains it;
- a flag cannot be high after the enable has been low for three cycles.

Some behaviour cannot be seen in a single domain and is shown only by the bench scenarios. These scenarios cover:
- the divider ratio picked by each configuration, measured as reference periods in time;
- how long detection takes after a clock is gated off;
- the absence of false alarms when both clocks run at legal ratios.

// File: rtl/xclk_pkg.sv
package xclk_pkg;

    localparam int unsigned DEF_SHORT_LOG2 = 2;
    localparam int unsigned DEF_LONG_LOG2  = 7;
    localparam int unsigned DEF_XTAL_LOG2  = 8;
    localparam int unsigned DEF_MISS_LIMIT = 2;

    typedef enum logic {
        PATH_EXT = 1'b0,
        PATH_INT = 1'b1
    } path_e;

    typedef struct packed {
        logic ext_slow;
        logic xtal_en;
    } cfg_t;

    typedef struct packed {
        logic en;
        logic clr;
    } ctl_t;

    // log2 of the total divide applied on one path for the given configuration
    function automatic int unsigned ref_log2(
        input path_e       path,
        input cfg_t        cfg,
        input int unsigned short_l2,
        input int unsigned long_l2,
        input int unsigned xtal_l2
    );
        logic long_here;
        long_here = (path == PATH_EXT) ? !cfg.ext_slow : cfg.ext_slow;
        if (!long_here)
            return short_l2;
        if (path == PATH_EXT && cfg.xtal_en)
            return xtal_l2;
        return long_l2;
    endfunction

endpackage

// File: rtl/xclk_sync.sv
module xclk_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/xclk_refgen.sv
module xclk_refgen
    import xclk_pkg::*;
#(
    parameter path_e       PATH       = PATH_EXT,
    parameter int unsigned SHORT_LOG2 = DEF_SHORT_LOG2,
    parameter int unsigned LONG_LOG2  = DEF_LONG_LOG2,
    parameter int unsigned XTAL_LOG2  = DEF_XTAL_LOG2
) (
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    output logic ref_o
);
    localparam int CNT_W = XTAL_LOG2;
    localparam int IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

    logic [CNT_W-1:0] div_cnt;
    logic [IDX_W-1:0] tap;

    always_comb
        tap = IDX_W'(ref_log2(PATH, cfg, SHORT_LOG2, LONG_LOG2, XTAL_LOG2) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            ref_o   <= 1'b0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            ref_o   <= div_cnt[tap];
        end
    end
endmodule

// File: rtl/xclk_detector.sv
module xclk_detector #(
    parameter int unsigned MISS_LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic ref_i,
    input  logic mon_clk,
    output logic fail
);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [MISS_W-1:0] LAST_OK = MISS_W'(MISS_LIMIT - 1);
    localparam logic [MISS_W-1:0] SAT     = MISS_W'(MISS_LIMIT);

    logic              ref_q;
    logic              ref_rise;
    logic              wipe_q;
    logic              seen;
    logic              seen_s;
    logic [MISS_W-1:0] miss_cnt;

    // activity capture: set by any monitored edge, wiped from the checker domain
    always_ff @(posedge mon_clk or posedge wipe_q) begin
        if (wipe_q) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    xclk_sync #(.W(1)) u_seen_sync (
        .clk (clk),
        .rst (rst),
        .d   (seen),
        .q   (seen_s)
    );

    assign ref_rise = ref_i & ~ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q    <= 1'b0;
            wipe_q   <= 1'b1;
            miss_cnt <= '0;
            fail     <= 1'b0;
        end else begin
            ref_q  <= ref_i;
            wipe_q <= ref_rise | ~en;
            if (!en || clr) begin
                miss_cnt <= '0;
                fail     <= 1'b0;
            end else if (ref_rise) begin
                if (seen_s) begin
                    miss_cnt <= '0;
                end else begin
                    if (miss_cnt != SAT) miss_cnt <= miss_cnt + 1'b1;
                    if (miss_cnt == LAST_OK) fail <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xclk_monitor.sv
module xclk_monitor
    import xclk_pkg::*;
#(
    parameter int unsigned SHORT_LOG2 = DEF_SHORT_LOG2,
    parameter int unsigned LONG_LOG2  = DEF_LONG_LOG2,
    parameter int unsigned XTAL_LOG2  = DEF_XTAL_LOG2,
    parameter int unsigned MISS_LIMIT = DEF_MISS_LIMIT
) (
    input  logic ext_clk,
    input  logic ibase_clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic ext_slow,
    input  logic xtal_en,
    output logic eref,
    output logic iref,
    output logic ext_fail,
    output logic int_fail
);
    localparam int NPATH = 2;

    cfg_t             cfg;
    logic [NPATH-1:0] dom_clk;
    logic [NPATH-1:0] ref_v;
    logic [NPATH-1:0] fail_v;

    assign cfg     = '{ext_slow: ext_slow, xtal_en: xtal_en};
    assign dom_clk = {ibase_clk, ext_clk};

    // path g: reference built in domain g, monitoring the clock of the other domain
    for (genvar g = 0; g < NPATH; g++) begin : g_path
        ctl_t ctl_s;

        xclk_sync #(.W(2)) u_ctl_sync (
            .clk (dom_clk[g]),
            .rst (rst),
            .d   ({en, clr}),
            .q   (ctl_s)
        );

        xclk_refgen #(
            .PATH       (path_e'(g)),
            .SHORT_LOG2 (SHORT_LOG2),
            .LONG_LOG2  (LONG_LOG2),
            .XTAL_LOG2  (XTAL_LOG2)
        ) u_refgen (
            .clk   (dom_clk[g]),
            .rst   (rst),
            .cfg   (cfg),
            .ref_o (ref_v[g])
        );

        xclk_detector #(.MISS_LIMIT(MISS_LIMIT)) u_det (
            .clk     (dom_clk[g]),
            .rst     (rst),
            .en      (ctl_s.en),
            .clr     (ctl_s.clr),
            .ref_i   (ref_v[g]),
            .mon_clk (dom_clk[NPATH-1-g]),
            .fail    (fail_v[g])
        );
    end

    assign eref     = ref_v[0];
    assign iref     = ref_v[1];
    assign int_fail = fail_v[0];
    assign ext_fail = fail_v[1];
endmodule

// File: rtl/xclk_monitor_chk.sv
module xclk_monitor_chk (
    input logic ext_clk,
    input logic ibase_clk,
    input logic rst,
    input logic en,
    input logic clr,
    input logic eref,
    input logic iref,
    input logic ext_fail,
    input logic int_fail
);
    // R5: the external-clock flag rises only in the cycle after an iref rising edge
    p_ext_fail_on_ref_r5: assert property (@(posedge ibase_clk) disable iff (rst)
        $rose(ext_fail) |-> ($past(iref) && !$past(iref, 2)));

    // R6: the base-clock flag rises only in the cycle after an eref rising edge
    p_int_fail_on_ref_r6: assert property (@(posedge ext_clk) disable iff (rst)
        $rose(int_fail) |-> ($past(eref) && !$past(eref, 2)));

    // R7: a set flag drops only through a synchronised disable, clear or reset
    p_ext_sticky_r7: assert property (@(posedge ibase_clk) disable iff (rst)
        $fell(ext_fail) |-> (!$past(en, 3) || $past(clr, 3) || $past(rst)));

    p_int_sticky_r7: assert property (@(posedge ext_clk) disable iff (rst)
        $fell(int_fail) |-> (!$past(en, 3) || $past(clr, 3) || $past(rst)));

    // R9: after three low enable samples the flag of that domain is low
    p_ext_off_r9: assert property (@(posedge ibase_clk) disable iff (rst)
        (!en && !$past(en) && !$past(en, 2)) |=> !ext_fail);

    p_int_off_r9: assert property (@(posedge ext_clk) disable iff (rst)
        (!en && !$past(en) && !$past(en, 2)) |=> !int_fail);
endmodule

bind xclk_monitor xclk_monitor_chk u_chk (
    .ext_clk   (ext_clk),
    .ibase_clk (ibase_clk),
    .rst       (rst),
    .en        (en),
    .clr       (clr),
    .eref      (eref),
    .iref      (iref),
    .ext_fail  (ext_fail),
    .int_fail  (int_fail)
);

// File: tb/tb_xclk_monitor.sv
`timescale 1ns/100ps
module tb_xclk_monitor;

    logic ext_clk = 1'b0;
    logic ibase_clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic clr = 1'b0;
    logic ext_slow = 1'b0;
    logic xtal_en = 1'b0;
    logic eref, iref, ext_fail, int_fail;

    logic i_run = 1'b1;
    logic e_run = 1'b1;
    int   e_half = 3;
    int   n_checks = 0;
    int   n_errors = 0;
    logic done = 1'b0;

    localparam int IB_PERIOD = 10;
    localparam int WATCHDOG_NS = 1_500_000;

    // columns: ext_slow, xtal_en, ext half period (ns), eref log2 divide, iref log2 divide
    localparam int NVEC = 4;
    localparam int VEC [NVEC][5] = '{
        '{0, 0, 3, 7, 2},
        '{0, 1, 3, 8, 2},
        '{1, 0, 40, 2, 7},
        '{1, 1, 40, 2, 7}
    };

    xclk_monitor dut (
        .ext_clk   (ext_clk),
        .ibase_clk (ibase_clk),
        .rst       (rst),
        .en        (en),
        .clr       (clr),
        .ext_slow  (ext_slow),
        .xtal_en   (xtal_en),
        .eref      (eref),
        .iref      (iref),
        .ext_fail  (ext_fail),
        .int_fail  (int_fail)
    );

    always begin
        #(IB_PERIOD / 2);
        if (i_run) ibase_clk = ~ibase_clk;
    end

    always begin
        #(e_half);
        if (e_run) ext_clk = ~ext_clk;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure_eref(output int p);
        time t0;
        @(posedge eref);
        @(posedge eref);
        t0 = $time;
        @(posedge eref);
        p = int'($time - t0);
        #0.5;
    endtask

    task automatic measure_iref(output int p);
        time t0;
        @(posedge iref);
        @(posedge iref);
        t0 = $time;
        @(posedge iref);
        p = int'($time - t0);
        #0.5;
    endtask

    task automatic setup(input int slow, input int xt, input int half);
        en = 1'b0;
        #200;
        ext_slow = slow[0];
        xtal_en = xt[0];
        e_half = half;
        #600;
        en = 1'b1;
        #2000;
    endtask

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int pe, pi, wait_ns;
        #0.5;
        // R10: reset state with both clocks running
        #400;
        check("R10 eref in reset", int'(eref), 0);
        check("R10 iref in reset", int'(iref), 0);
        check("R10 ext_fail in reset", int'(ext_fail), 0);
        check("R10 int_fail in reset", int'(int_fail), 0);
        rst = 1'b0;
        #2000;
        // R9: disabled after reset, flags low
        check("R9 ext_fail disabled", int'(ext_fail), 0);
        check("R9 int_fail disabled", int'(int_fail), 0);

        // table walk: R1 R2 R3 R4
        for (int v = 0; v < NVEC; v++) begin
            setup(VEC[v][0], VEC[v][1], VEC[v][2]);
            measure_eref(pe);
            check((VEC[v][0] == 1) ? "R3 eref period" : "R1 eref period",
                  pe, 2 * VEC[v][2] * (1 << VEC[v][3]));
            measure_iref(pi);
            check((VEC[v][0] == 1) ? "R3 iref period" : "R2 iref period",
                  pi, IB_PERIOD * (1 << VEC[v][4]));
            wait_ns = 4 * ((pe > pi) ? pe : pi);
            #(wait_ns);
            check("R4 no ext_fail at legal ratio", int'(ext_fail), 0);
            check("R4 no int_fail at legal ratio", int'(int_fail), 0);
        end

        // directed: fast external clock, iref = 40 ns, eref = 768 ns
        setup(0, 0, 3);
        check("R4 ext_fail before stop", int'(ext_fail), 0);
        e_run = 1'b0;
        #160;
        check("R5 ext_fail after external stop", int'(ext_fail), 1);
        check("R5 int_fail after external stop", int'(int_fail), 0);
        e_run = 1'b1;
        #1000;
        check("R7 ext_fail sticky after restart", int'(ext_fail), 1);
        clr = 1'b1;
        #200;
        clr = 1'b0;
        #100;
        check("R8 ext_fail cleared", int'(ext_fail), 0);
        #4000;
        check("R8 ext_fail stays clear", int'(ext_fail), 0);

        i_run = 1'b0;
        #3072;
        check("R6 int_fail after base stop", int'(int_fail), 1);
        check("R6 ext_fail after base stop", int'(ext_fail), 0);
        i_run = 1'b1;
        #2000;
        check("R7 int_fail sticky after restart", int'(int_fail), 1);

        en = 1'b0;
        #100;
        check("R9 int_fail dropped on disable", int'(int_fail), 0);
        e_run = 1'b0;
        #2000;
        check("R9 ext_fail low while disabled and stopped", int'(ext_fail), 0);
        i_run = 1'b0;
        e_run = 1'b1;
        #4000;
        check("R9 int_fail low while disabled and stopped", int'(int_fail), 0);
        i_run = 1'b1;
        #500;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule